// File: doc/BRIEF.md
# DRAM Mode-Register Initialization Sequencer

This block walks an SDRAM device through its power-up command sequence once the device has been powered and its clock is running. A one-cycle start pulse latches the memory type and the mode-register values, and the sequencer then hands each command in turn to a memory-controller command port. It holds each request until the port acknowledges it, and places microsecond-scale pauses between commands with a cycle-counting timer. A one-cycle done pulse marks the end of the sequence.

The sequencer follows one of two paths, chosen by the memory type. The DDR3 path has these states: `S_D_DES` (deselect) → `S_D_DES_W` (1 µs pause) → `S_D_PREA` (precharge all) → `S_D_MR2` → `S_D_MR3` → `S_D_MR1` → `S_D_MR0` (DLL reset forced) → `S_D_ZQ` (long ZQ calibration) → `S_DONE`. The LPDDR2/LPDDR3 path has these states: `S_L_RST` (register 0x3F, reset) → `S_L_RST_W` (10 µs) → `S_L_CALA` → `S_L_CALA_W` (1 µs) → `S_L_CALB` → `S_L_CALB_W` (1 µs) → `S_L_MR1` → `S_L_MR2` → `S_L_MR3` → `S_L_MR11` (LPDDR3 only) → `S_DONE`. `S_IDLE` leaves on start and `S_DONE` returns to `S_IDLE` after one cycle. In each command state the request is raised one cycle after entry and the state advances on the acknowledge. Each pause state advances when its timer runs out.

Top module: `dram_mr_init_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `cmd_start_o` are low.
- R2: Every issued command carries rank code 3 (both ranks) on `cmd_rank_o`.
- R3: `cmd_start_o` stays high with a stable code and argument until `cmd_ack_i` is sampled high, and falls in the next cycle. Without an intervening pause, the next request rises one cycle after the acknowledge. `cmd_ack_i` has no effect while no request is pending.
- R4: With `mem_kind_i`=0 (DDR3) the commands are: deselect (code 1), precharge-all (code 2), mode writes (code 3) to bank 2, 3, 1, 0 carrying `mr2_i`, `mr3_i`, `mr1_i`, `mr0_i`, then long ZQ calibration (code 4). The DDR3 argument holds the bank in bits [16:14] and the address in bits [13:0]. Deselect, precharge and ZQ carry a zero argument.
- R5: The DDR3 mode write to bank 0 has address bit 8 (DLL reset) set, whatever the value of `mr0_i`.
- R6: With DDR3, the precharge request rises `CYC_PER_US`+1 cycles after the deselect acknowledge (a 1 µs pause).
- R7: For any other type, the sequence opens with three mode writes (code 3): register 0x3F with operand 0x00, then register 0x0A with operand 0xFF twice. The pauses after them are 10 µs, 1 µs and 1 µs, so each following request rises 10·`CYC_PER_US`+1, `CYC_PER_US`+1 and `CYC_PER_US`+1 cycles after the acknowledge. The LPDDR argument holds the register address in bits [15:8], the operand in bits [7:0], and bit 16 is zero.
- R8: The LPDDR path then writes registers 1, 2, 3 with the low 8 bits of `mr1_i`, `mr2_i`, `mr3_i`. It writes register 11 with `mr11_i` only when `mem_kind_i`=2.
- R9: `done_o` is high for exactly one cycle: the cycle after the last acknowledge is sampled. `busy_o` is low from the following cycle on.
- R10: A start pulse while busy is ignored, and the type and register values are those sampled with the accepted start.
- R11: `mem_kind_i` codes are 0 DDR3, 1 LPDDR2, 2 LPDDR3. Code 3 runs the LPDDR2 sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mem_kind_i | input | 2 | Memory type code |
| mr0_i | input | 14 | Mode register 0 value |
| mr1_i | input | 14 | Mode register 1 value |
| mr2_i | input | 14 | Mode register 2 value |
| mr3_i | input | 14 | Mode register 3 value |
| mr11_i | input | 8 | LPDDR3 register 11 operand |
| cmd_ack_i | input | 1 | Command-port completion |
| cmd_start_o | output | 1 | Command request (start bit) |
| cmd_rank_o | output | 2 | Rank select |
| cmd_code_o | output | 3 | Command opcode |
| cmd_arg_o | output | 17 | Command argument |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a start pulse that arrives in the middle of a sequence with different type and register values. It must change nothing, so the bench fires one during a run with altered inputs and compares the full command list against the originally latched values. The pause lengths only show up as the spacing between an acknowledge and the next request. For that reason the bench answers every request after a random latency of 0 to 3 cycles and measures each gap in cycles, so that both the short gaps and the timed gaps are checked on every run.

// File: rtl/dmis_pkg.sv
package dmis_pkg;

    typedef enum logic [1:0] {
        KIND_DDR3   = 2'd0,
        KIND_LPDDR2 = 2'd1,
        KIND_LPDDR3 = 2'd2,
        KIND_RSVD   = 2'd3
    } mem_kind_e;

    localparam logic [2:0] OP_DESELECT      = 3'd1;
    localparam logic [2:0] OP_PRECHARGE_ALL = 3'd2;
    localparam logic [2:0] OP_MODE_WRITE    = 3'd3;
    localparam logic [2:0] OP_ZQ_LONG       = 3'd4;

    typedef enum logic [4:0] {
        S_IDLE,
        S_D_DES, S_D_DES_W, S_D_PREA,
        S_D_MR2, S_D_MR3, S_D_MR1, S_D_MR0, S_D_ZQ,
        S_L_RST, S_L_RST_W, S_L_CALA, S_L_CALA_W, S_L_CALB, S_L_CALB_W,
        S_L_MR1, S_L_MR2, S_L_MR3, S_L_MR11,
        S_DONE
    } seq_state_e;

    function automatic int arg_width(input int ba_w, input int addr_w,
                                     input int ma_w, input int op_w);
        return (ba_w + addr_w > ma_w + op_w) ? ba_w + addr_w : ma_w + op_w;
    endfunction

endpackage

// File: rtl/mis_us_timer.sv
module mis_us_timer #(
    parameter int CYC_PER_US = 100,
    parameter int MAX_US     = 10,
    localparam int CW        = $clog2(MAX_US * CYC_PER_US + 1),
    localparam int US_W      = $clog2(MAX_US + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [US_W-1:0] us_i,
    output logic            last_o
);
    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= CW'(int'(us_i) * CYC_PER_US);
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign last_o = (count_q == CW'(1));

    // R6: the pause shrinks by one each cycle until it expires
    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q > CW'(1) && !load_i) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/mis_cmd_pack.sv
module mis_cmd_pack #(
    parameter int ADDR_W = 14,
    parameter int BA_W   = 3,
    parameter int MA_W   = 8,
    parameter int OP_W   = 8,
    parameter int ARG_W  = 17
) (
    input  logic              is_lp_i,
    input  logic [MA_W-1:0]   idx_i,
    input  logic [ADDR_W-1:0] val_i,
    output logic [ARG_W-1:0]  arg_o
);
    always_comb begin
        arg_o = '0;
        if (is_lp_i) begin
            arg_o[OP_W-1:0]    = val_i[OP_W-1:0];
            arg_o[OP_W +: MA_W] = idx_i;
        end else begin
            arg_o[ADDR_W-1:0]     = val_i;
            arg_o[ADDR_W +: BA_W] = idx_i[BA_W-1:0];
        end
    end
endmodule

// File: rtl/dram_mr_init_seq.sv
module dram_mr_init_seq
    import dmis_pkg::*;
#(
    parameter int CYC_PER_US    = 100,
    parameter int ADDR_W        = 14,
    parameter int BA_W          = 3,
    parameter int MA_W          = 8,
    parameter int OP_W          = 8,
    parameter int LONG_WAIT_US  = 10,
    parameter int SHORT_WAIT_US = 1,
    parameter int DLL_RST_BIT   = 8,
    localparam int ARG_W        = arg_width(BA_W, ADDR_W, MA_W, OP_W),
    localparam int US_W         = $clog2(LONG_WAIT_US + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mem_kind_i,
    input  logic [ADDR_W-1:0] mr0_i,
    input  logic [ADDR_W-1:0] mr1_i,
    input  logic [ADDR_W-1:0] mr2_i,
    input  logic [ADDR_W-1:0] mr3_i,
    input  logic [OP_W-1:0]   mr11_i,
    input  logic              cmd_ack_i,
    output logic              cmd_start_o,
    output logic [1:0]        cmd_rank_o,
    output logic [2:0]        cmd_code_o,
    output logic [ARG_W-1:0]  cmd_arg_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [1:0] RANK_BOTH = 2'b11;

    seq_state_e        state_q, nxt;
    mem_kind_e         kind_q;
    logic [ADDR_W-1:0] mr0_q, mr1_q, mr2_q, mr3_q;
    logic [OP_W-1:0]   mr11_q;
    logic              start_q;
    logic [2:0]        code_q;
    logic [ARG_W-1:0]  arg_q;

    logic              is_cmd, is_lp, tmr_last, tmr_load;
    logic [2:0]        cur_code;
    logic [MA_W-1:0]   cur_idx;
    logic [ADDR_W-1:0] cur_val;
    logic [US_W-1:0]   nxt_us;
    logic [ARG_W-1:0]  packed_arg;

    // decode: what the current state issues and where it goes next
    always_comb begin
        cur_code = OP_MODE_WRITE;
        cur_idx  = '0;
        cur_val  = '0;
        nxt      = state_q;
        nxt_us   = '0;
        is_cmd   = 1'b1;
        is_lp    = (kind_q != KIND_DDR3);
        unique case (state_q)
            S_IDLE: begin
                is_cmd = 1'b0;
                nxt    = (mem_kind_e'(mem_kind_i) == KIND_DDR3) ? S_D_DES : S_L_RST;
            end
            S_D_DES: begin
                cur_code = OP_DESELECT;
                nxt      = S_D_DES_W;
                nxt_us   = US_W'(SHORT_WAIT_US);
            end
            S_D_DES_W: begin
                is_cmd = 1'b0;
                nxt    = S_D_PREA;
            end
            S_D_PREA: begin
                cur_code = OP_PRECHARGE_ALL;
                nxt      = S_D_MR2;
            end
            S_D_MR2: begin
                cur_idx = MA_W'(2);
                cur_val = mr2_q;
                nxt     = S_D_MR3;
            end
            S_D_MR3: begin
                cur_idx = MA_W'(3);
                cur_val = mr3_q;
                nxt     = S_D_MR1;
            end
            S_D_MR1: begin
                cur_idx = MA_W'(1);
                cur_val = mr1_q;
                nxt     = S_D_MR0;
            end
            S_D_MR0: begin
                cur_idx = MA_W'(0);
                cur_val = mr0_q | (ADDR_W'(1) << DLL_RST_BIT);
                nxt     = S_D_ZQ;
            end
            S_D_ZQ: begin
                cur_code = OP_ZQ_LONG;
                nxt      = S_DONE;
            end
            S_L_RST: begin
                cur_idx = MA_W'(8'h3F);
                nxt     = S_L_RST_W;
                nxt_us  = US_W'(LONG_WAIT_US);
            end
            S_L_RST_W: begin
                is_cmd = 1'b0;
                nxt    = S_L_CALA;
            end
            S_L_CALA: begin
                cur_idx = MA_W'(8'h0A);
                cur_val = ADDR_W'(8'hFF);
                nxt     = S_L_CALA_W;
                nxt_us  = US_W'(SHORT_WAIT_US);
            end
            S_L_CALA_W: begin
                is_cmd = 1'b0;
                nxt    = S_L_CALB;
            end
            S_L_CALB: begin
                cur_idx = MA_W'(8'h0A);
                cur_val = ADDR_W'(8'hFF);
                nxt     = S_L_CALB_W;
                nxt_us  = US_W'(SHORT_WAIT_US);
            end
            S_L_CALB_W: begin
                is_cmd = 1'b0;
                nxt    = S_L_MR1;
            end
            S_L_MR1: begin
                cur_idx = MA_W'(1);
                cur_val = mr1_q;
                nxt     = S_L_MR2;
            end
            S_L_MR2: begin
                cur_idx = MA_W'(2);
                cur_val = mr2_q;
                nxt     = S_L_MR3;
            end
            S_L_MR3: begin
                cur_idx = MA_W'(3);
                cur_val = mr3_q;
                nxt     = (kind_q == KIND_LPDDR3) ? S_L_MR11 : S_DONE;
            end
            S_L_MR11: begin
                cur_idx = MA_W'(11);
                cur_val = ADDR_W'(mr11_q);
                nxt     = S_DONE;
            end
            S_DONE: begin
                is_cmd = 1'b0;
                nxt    = S_IDLE;
            end
            default: begin
                is_cmd = 1'b0;
                nxt    = S_IDLE;
            end
        endcase
    end

    mis_cmd_pack #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .MA_W(MA_W), .OP_W(OP_W), .ARG_W(ARG_W)
    ) u_pack (
        .is_lp_i (is_lp),
        .idx_i   (cur_idx),
        .val_i   (cur_val),
        .arg_o   (packed_arg)
    );

    assign tmr_load = is_cmd && start_q && cmd_ack_i && (nxt_us != '0);

    mis_us_timer #(
        .CYC_PER_US(CYC_PER_US), .MAX_US(LONG_WAIT_US)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .us_i   (nxt_us),
        .last_o (tmr_last)
    );

    // state register, configuration capture and command-port register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= KIND_DDR3;
            mr0_q   <= '0;
            mr1_q   <= '0;
            mr2_q   <= '0;
            mr3_q   <= '0;
            mr11_q  <= '0;
            start_q <= 1'b0;
            code_q  <= '0;
            arg_q   <= '0;
        end else if (state_q == S_IDLE) begin
            if (start_i) begin
                kind_q  <= mem_kind_e'(mem_kind_i);
                mr0_q   <= mr0_i;
                mr1_q   <= mr1_i;
                mr2_q   <= mr2_i;
                mr3_q   <= mr3_i;
                mr11_q  <= mr11_i;
                state_q <= nxt;
            end
        end else if (is_cmd) begin
            if (!start_q) begin
                start_q <= 1'b1;
                code_q  <= cur_code;
                arg_q   <= packed_arg;
            end else if (cmd_ack_i) begin
                start_q <= 1'b0;
                state_q <= nxt;
            end
        end else if (state_q == S_DONE || tmr_last) begin
            state_q <= nxt;
        end
    end

    // outputs
    always_comb begin
        cmd_start_o = start_q;
        cmd_rank_o  = RANK_BOTH;
        cmd_code_o  = code_q;
        cmd_arg_o   = arg_q;
        busy_o      = (state_q != S_IDLE);
        done_o      = (state_q == S_DONE);
    end

    p_hold_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_o && !cmd_ack_i) |=>
            (cmd_start_o && $stable(cmd_arg_o) && $stable(cmd_code_o)));

    p_drop_after_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_o && cmd_ack_i) |=> !cmd_start_o);

    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cmd_start_o);

    p_dll_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start_o && state_q == S_D_MR0) |-> cmd_arg_o[DLL_RST_BIT]);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));

endmodule

// File: tb/dram_mr_init_seq_tb.sv
module dram_mr_init_seq_tb;
    localparam int CYC    = 20;
    localparam int ADDR_W = 14;
    localparam int ARG_W  = 17;
    localparam int MAXC   = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] kind_i = 2'd0;
    logic [ADDR_W-1:0] mr0_i = '0, mr1_i = '0, mr2_i = '0, mr3_i = '0;
    logic [7:0] mr11_i = '0;
    logic cmd_ack_i;
    logic model_ack = 1'b0;
    logic spur_ack = 1'b0;
    logic cmd_start_o, busy_o, done_o;
    logic [1:0] cmd_rank_o;
    logic [2:0] cmd_code_o;
    logic [ARG_W-1:0] cmd_arg_o;

    assign cmd_ack_i = model_ack | spur_ack;

    dram_mr_init_seq #(.CYC_PER_US(CYC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_kind_i(kind_i),
        .mr0_i(mr0_i), .mr1_i(mr1_i), .mr2_i(mr2_i), .mr3_i(mr3_i),
        .mr11_i(mr11_i), .cmd_ack_i(cmd_ack_i), .cmd_start_o(cmd_start_o),
        .cmd_rank_o(cmd_rank_o), .cmd_code_o(cmd_code_o),
        .cmd_arg_o(cmd_arg_o), .busy_o(busy_o), .done_o(done_o)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;

    // command-port model and log
    logic [2:0]       lg_code [MAXC];
    logic [ARG_W-1:0] lg_arg  [MAXC];
    logic [1:0]       lg_rank [MAXC];
    int lg_start [MAXC];
    int lg_ackc  [MAXC];
    int lg_n = 0;
    bit pend = 0;
    int lat = 0;
    int done_cnt = 0;
    int done_cyc = 0;

    always @(negedge clk) begin
        if (cmd_start_o && !pend) begin
            if (lg_n < MAXC) begin
                lg_code[lg_n]  = cmd_code_o;
                lg_arg[lg_n]   = cmd_arg_o;
                lg_rank[lg_n]  = cmd_rank_o;
                lg_start[lg_n] = cyc;
            end
            lg_n = lg_n + 1;
            pend = 1;
            lat  = int'($urandom_range(0, 3));
        end
        if (pend) begin
            if (lat == 0) begin
                model_ack = 1'b1;
                pend = 0;
                if (lg_n <= MAXC) lg_ackc[lg_n-1] = cyc + 1;
            end else begin
                lat = lat - 1;
                model_ack = 1'b0;
            end
        end else begin
            model_ack = 1'b0;
        end
        if (done_o) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected sequence, built from the requirements
    logic [2:0]       ex_code [MAXC];
    logic [ARG_W-1:0] ex_arg  [MAXC];
    int    ex_gap [MAXC];
    string ex_req [MAXC];
    int    ex_n;

    function automatic logic [ARG_W-1:0] ddr_arg(input int bank, input logic [13:0] a);
        return {bank[2:0], a};
    endfunction

    function automatic logic [ARG_W-1:0] lp_arg(input int ma, input logic [7:0] op);
        return {1'b0, ma[7:0], op};
    endfunction

    task automatic add(input logic [2:0] c, input logic [ARG_W-1:0] a, input int g,
                       input string r);
        ex_code[ex_n] = c; ex_arg[ex_n] = a; ex_gap[ex_n] = g; ex_req[ex_n] = r;
        ex_n++;
    endtask

    task automatic build_exp(input int kind, input logic [13:0] m0, m1, m2, m3,
                             input logic [7:0] m11);
        ex_n = 0;
        if (kind == 0) begin
            add(3'd1, '0, 0, "R4");
            add(3'd2, '0, 1 + CYC, "R6");
            add(3'd3, ddr_arg(2, m2), 1, "R4");
            add(3'd3, ddr_arg(3, m3), 1, "R4");
            add(3'd3, ddr_arg(1, m1), 1, "R4");
            add(3'd3, ddr_arg(0, m0 | 14'h0100), 1, "R5");
            add(3'd4, '0, 1, "R4");
        end else begin
            add(3'd3, lp_arg(8'h3F, 8'h00), 0, "R7");
            add(3'd3, lp_arg(8'h0A, 8'hFF), 1 + 10 * CYC, "R7");
            add(3'd3, lp_arg(8'h0A, 8'hFF), 1 + CYC, "R7");
            add(3'd3, lp_arg(1, m1[7:0]), 1 + CYC, "R8");
            add(3'd3, lp_arg(2, m2[7:0]), 1, "R8");
            add(3'd3, lp_arg(3, m3[7:0]), 1, "R8");
            if (kind == 2) add(3'd3, lp_arg(11, m11), 1, "R8");
        end
    endtask

    task automatic run_seq(input int kind, input logic [13:0] m0, m1, m2, m3,
                           input logic [7:0] m11, input bit poke);
        int d0;
        int t;
        string kreq;
        build_exp(kind, m0, m1, m2, m3, m11);
        kreq = (kind == 3) ? "R11" : (poke ? "R10" : ex_req[ex_n-1]);
        lg_n = 0;
        d0 = done_cnt;
        @(negedge clk);
        kind_i = kind[1:0]; mr0_i = m0; mr1_i = m1; mr2_i = m2; mr3_i = m3; mr11_i = m11;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            kind_i = ~kind_i; mr0_i = ~m0; mr1_i = ~m1; mr2_i = ~m2; mr3_i = ~m3;
            mr11_i = ~m11;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        t = 0;
        while (done_cnt == d0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(t < 20000, "R9", "sequence finished", t, 0);
        repeat (3) @(negedge clk);
        check(lg_n == ex_n, kreq, "command count", lg_n, ex_n);
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            check(lg_code[i] == ex_code[i], kreq, "opcode", lg_code[i], ex_code[i]);
            check(lg_arg[i] == ex_arg[i], ex_req[i], "argument", lg_arg[i], ex_arg[i]);
            check(lg_rank[i] == 2'b11, "R2", "rank", lg_rank[i], 3);
            if (i > 0)
                check(lg_start[i] - lg_ackc[i-1] == ex_gap[i],
                      (ex_gap[i] == 1) ? "R3" : ex_req[i], "gap cycles",
                      lg_start[i] - lg_ackc[i-1], ex_gap[i]);
        end
        check(done_cnt == d0 + 1, "R9", "done pulse count", done_cnt - d0, 1);
        if (lg_n > 0 && lg_n <= MAXC)
            check(done_cyc == lg_ackc[lg_n-1], "R9", "done cycle",
                  done_cyc, lg_ackc[lg_n-1]);
        check(busy_o == 1'b0, "R9", "busy after done", busy_o, 0);
    endtask

    task automatic finish_up();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_up();
    end

    initial begin
        int seed_init;
        seed_init = int'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !cmd_start_o, "R1", "in reset",
              {busy_o, done_o, cmd_start_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy_o && !done_o && !cmd_start_o, "R1", "after reset",
              {busy_o, done_o, cmd_start_o}, 0);

        // R3: acknowledge while idle changes nothing
        spur_ack = 1'b1;
        repeat (3) @(negedge clk);
        spur_ack = 1'b0;
        @(negedge clk);
        check(!busy_o && !cmd_start_o && lg_n == 0, "R3", "idle ack ignored",
              {busy_o, cmd_start_o}, 0);

        // directed corners
        run_seq(0, 14'h0000, 14'h0044, 14'h0018, 14'h0000, 8'h00, 1'b0); // R5 bit forced
        run_seq(0, 14'h3FFF, 14'h2AAA, 14'h1555, 14'h3FFF, 8'h00, 1'b0);
        run_seq(2, 14'h3FC3, 14'h1283, 14'h0406, 14'h0002, 8'h03, 1'b0); // R8 MR11
        run_seq(1, 14'h3FC3, 14'h1283, 14'h0406, 14'h0002, 8'h03, 1'b0);
        run_seq(3, 14'h0001, 14'h00A5, 14'h005A, 14'h0033, 8'h77, 1'b0); // R11
        run_seq(0, 14'h0520, 14'h0006, 14'h0008, 14'h0000, 8'h00, 1'b1); // R10
        run_seq(2, 14'h0000, 14'h00C3, 14'h0006, 14'h0001, 8'h02, 1'b1); // R10

        // constrained random
        for (int k = 0; k < 8; k++) begin
            run_seq(int'($urandom_range(0, 3)), 14'($urandom), 14'($urandom),
                    14'($urandom), 14'($urandom), 8'($urandom), k[0]);
        end
        finish_up();
    end
endmodule